// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general-purpose registers of a 32-bit processor that runs in several operating modes. An instruction names a register by a 4-bit architectural index. The current mode decides which physical copy that index reaches. The low registers are common to every mode. The upper registers are private copies that belong to the exception modes. The fast-interrupt mode owns the largest private set, so its handler can run without saving working registers. The other exception modes own only a private stack pointer (index 13) and a private link register (index 14).

There are two combinational read ports and one write port that is clocked. A bank-override input sends every access through the user copies, whatever the current mode, so that privileged code can save or restore a user context. Index 15 is the program counter slot, which is handled elsewhere. Here that index reads as zero and accepts no writes.

Top module: `banked_reg_file`

## Requirements
- R1: A synchronous active-high reset clears every physical copy to zero. After reset, any index read in any mode returns 0.
- R2: Indices 0 to 7 reach the same physical register in every mode, with or without the bank override.
- R3: User mode (code 5'b10000) and system mode (code 5'b11111) share one copy of each of indices 0 to 14. Any mode code not listed in R3 to R5 behaves as user mode.
- R4: Fast-interrupt mode (code 5'b10001) has its own copies of indices 8 to 14, which no other mode sees.
- R5: Interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have their own copies of indices 13 and 14. For indices 8 to 12 they use the user copies.
- R6: When the bank-override input is 1, both reads and writes reach the user copies, whatever the mode input.
- R7: Reading index 15 on either port returns 0. A write to index 15 changes no register.
- R8: A read of the register being written in the same cycle returns the old contents. The new value is visible from the next cycle on.
- R9: The two read ports decode their indices independently and can read different registers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 5 | Current operating mode code |
| usr_bank_i | input | 1 | Bank override: 1 sends all accesses to the user copies |
| rd_a_idx_i | input | 4 | Read port A architectural index |
| rd_a_data_o | output | 32 | Read port A data (combinational) |
| rd_b_idx_i | input | 4 | Read port B architectural index |
| rd_b_data_o | output | 32 | Read port B data (combinational) |
| wr_en_i | input | 1 | Write enable |
| wr_idx_i | input | 4 | Write architectural index |
| wr_data_i | input | 32 | Write data |

## Verification
The bench targets the seams between banks:
- A design that gives the fast-interrupt mode too few private registers lets a write to index 8 or 12 in that mode leak into the user view.
- A design that gives the other exception modes too many private registers hides a write made in user mode at index 10.
- A design that ignores the bank override writes into the fast-interrupt copy instead of the user copy.
- Writes to index 15 and reads from an undefined mode code are directed at the edges of the decode. A wrong decode there would corrupt register 15's neighbour or select a private bank.
- A same-cycle read of the register being written would show the new value if a bypass had crept in.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

    localparam int DATA_W     = 32;
    localparam int IDX_W      = 4;
    localparam int ARCH_REGS  = 15;               // indices 0..14 live here
    localparam int FIQ_FIRST  = 8;                // first index private to fast interrupt
    localparam int PRIV_FIRST = 13;               // first index private to other exception modes
    localparam int PRIV_MODES = 4;
    localparam int RD_PORTS   = 2;

    localparam int FIQ_N     = ARCH_REGS - FIQ_FIRST;
    localparam int PRIV_N    = ARCH_REGS - PRIV_FIRST;
    localparam int FIQ_BASE  = ARCH_REGS;
    localparam int PRIV_BASE = FIQ_BASE + FIQ_N;
    localparam int NUM_PHYS  = PRIV_BASE + PRIV_MODES * PRIV_N;
    localparam int PHYS_W    = $clog2(NUM_PHYS);

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } cpu_mode_e;

    typedef struct packed {
        logic              ok;
        logic [PHYS_W-1:0] slot;
    } phys_ref_t;

    // Rank of a two-register exception bank; -1 when the mode has none.
    function automatic int priv_rank(input logic [4:0] mode);
        case (mode)
            MODE_IRQ: return 0;
            MODE_SVC: return 1;
            MODE_ABT: return 2;
            MODE_UND: return 3;
            default:  return -1;
        endcase
    endfunction

    function automatic phys_ref_t map_index(input logic [4:0]       mode,
                                            input logic             usr_force,
                                            input logic [IDX_W-1:0] idx);
        phys_ref_t r;
        int        rank;
        int        ix;
        ix     = int'(idx);
        rank   = priv_rank(mode);
        r.ok   = (ix < ARCH_REGS);
        r.slot = r.ok ? PHYS_W'(ix) : '0;
        if (r.ok && !usr_force) begin
            if (mode == MODE_FIQ && ix >= FIQ_FIRST)
                r.slot = PHYS_W'(FIQ_BASE + ix - FIQ_FIRST);
            else if (rank >= 0 && ix >= PRIV_FIRST)
                r.slot = PHYS_W'(PRIV_BASE + rank * PRIV_N + ix - PRIV_FIRST);
        end
        return r;
    endfunction

endpackage

// File: rtl/banked_rf_map.sv
module banked_rf_map
    import banked_rf_pkg::*;
(
    input  logic [4:0]       mode_i,
    input  logic             usr_force_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [PHYS_W-1:0] slot_o,
    output logic             ok_o
);
    phys_ref_t ref_q;

    always_comb begin
        ref_q  = map_index(mode_i, usr_force_i, idx_i);
        slot_o = ref_q.slot;
        ok_o   = ref_q.ok;
    end
endmodule

// File: rtl/banked_rf_store.sv
module banked_rf_store
    import banked_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [PHYS_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PHYS_W-1:0] raddr_i [RD_PORTS],
    output logic [DATA_W-1:0] rdata_o [RD_PORTS]
);
    logic [DATA_W-1:0] mem [NUM_PHYS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PHYS; i++) mem[i] <= '0;
        end else if (we_i) begin
            mem[waddr_i] <= wdata_i;
        end
    end

    // Plain flop read: no path from the write port, so a same-cycle read sees old data.
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        assign rdata_o[p] = mem[raddr_i[p]];
    end

    // R8: a committed write is held in its slot on the next cycle
    a_r8_write_lands: assert property (@(posedge clk) disable iff (rst)
        we_i |=> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/banked_reg_file.sv
module banked_reg_file
    import banked_rf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  mode_i,
    input  logic        usr_bank_i,
    input  logic [3:0]  rd_a_idx_i,
    output logic [31:0] rd_a_data_o,
    input  logic [3:0]  rd_b_idx_i,
    output logic [31:0] rd_b_data_o,
    input  logic        wr_en_i,
    input  logic [3:0]  wr_idx_i,
    input  logic [31:0] wr_data_i
);
    logic [IDX_W-1:0]  rd_idx  [RD_PORTS];
    logic [PHYS_W-1:0] rd_slot [RD_PORTS];
    logic              rd_ok   [RD_PORTS];
    logic [DATA_W-1:0] rd_raw  [RD_PORTS];
    logic [PHYS_W-1:0] wr_slot;
    logic              wr_ok;

    assign rd_idx[0] = rd_a_idx_i;
    assign rd_idx[1] = rd_b_idx_i;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rmap
        banked_rf_map u_rmap (
            .mode_i      (mode_i),
            .usr_force_i (usr_bank_i),
            .idx_i       (rd_idx[p]),
            .slot_o      (rd_slot[p]),
            .ok_o        (rd_ok[p])
        );
    end

    banked_rf_map u_wmap (
        .mode_i      (mode_i),
        .usr_force_i (usr_bank_i),
        .idx_i       (wr_idx_i),
        .slot_o      (wr_slot),
        .ok_o        (wr_ok)
    );

    banked_rf_store u_store (
        .clk     (clk),
        .rst     (rst),
        .we_i    (wr_en_i && wr_ok),
        .waddr_i (wr_slot),
        .wdata_i (wr_data_i),
        .raddr_i (rd_slot),
        .rdata_o (rd_raw)
    );

    assign rd_a_data_o = rd_ok[0] ? rd_raw[0] : '0;
    assign rd_b_data_o = rd_ok[1] ? rd_raw[1] : '0;

    // R1: the cycle after reset, both ports read zero
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data_o == '0 && rd_b_data_o == '0));

    // R2: low indices are shared by all modes
    a_r2_low_shared: assert property (@(posedge clk) disable iff (rst)
        (int'(wr_idx_i) < FIQ_FIRST) |-> (wr_slot == PHYS_W'(wr_idx_i)));

    // R4: fast-interrupt upper indices land outside the user bank
    a_r4_fiq_private: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_FIQ && !usr_bank_i && int'(rd_a_idx_i) >= FIQ_FIRST
         && int'(rd_a_idx_i) < ARCH_REGS) |-> (int'(rd_slot[0]) >= ARCH_REGS));

    // R6: the override keeps every valid access in the user bank
    a_r6_force_user: assert property (@(posedge clk) disable iff (rst)
        (usr_bank_i && wr_ok) |-> (int'(wr_slot) < ARCH_REGS));

    // R7: index 15 reads zero on both ports
    a_r7_pc_slot_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx_i == 4'hF) |-> (rd_a_data_o == '0));
    a_r7_pc_slot_zero_b: assert property (@(posedge clk) disable iff (rst)
        (rd_b_idx_i == 4'hF) |-> (rd_b_data_o == '0));
endmodule

// File: tb/tb_banked_reg_file.sv
module tb_banked_reg_file;
    localparam int CLK_P = 10;

    logic        clk = 0;
    logic        rst = 1;
    logic [4:0]  mode = 5'b10000;
    logic        ovr = 0;
    logic [3:0]  ra = 0, rb = 0, wi = 0;
    logic [31:0] rda, rdb, wd = 0;
    logic        we = 0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] m_usr [15];
    logic [31:0] m_fq  [7];
    logic [31:0] m_ex  [4][2];

    always #(CLK_P/2) clk = ~clk;

    banked_reg_file dut (
        .clk(clk), .rst(rst), .mode_i(mode), .usr_bank_i(ovr),
        .rd_a_idx_i(ra), .rd_a_data_o(rda),
        .rd_b_idx_i(rb), .rd_b_data_o(rdb),
        .wr_en_i(we), .wr_idx_i(wi), .wr_data_i(wd)
    );

    function automatic int ex_of(input logic [4:0] m);
        if (m == 5'b10010) return 0;
        if (m == 5'b10011) return 1;
        if (m == 5'b10111) return 2;
        if (m == 5'b11011) return 3;
        return -1;
    endfunction

    function automatic logic [31:0] model_rd(input logic [4:0] m, input logic o, input logic [3:0] i);
        int e;
        e = ex_of(m);
        if (i == 4'hF) return 32'h0;
        if (!o && m == 5'b10001 && i >= 8) return m_fq[i-8];
        if (!o && e >= 0 && i >= 13) return m_ex[e][i-13];
        return m_usr[i];
    endfunction

    task automatic model_wr(input logic [4:0] m, input logic o, input logic [3:0] i, input logic [31:0] d);
        int e;
        e = ex_of(m);
        if (i == 4'hF) return;
        if (!o && m == 5'b10001 && i >= 8) m_fq[i-8] = d;
        else if (!o && e >= 0 && i >= 13) m_ex[e][i-13] = d;
        else m_usr[i] = d;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check the reads, then commit at the rising edge.
    task automatic cyc(input string tag, input logic [4:0] m, input logic o,
                       input logic [3:0] a, input logic [3:0] b,
                       input logic w, input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        mode = m; ovr = o; ra = a; rb = b; we = w; wi = i; wd = d;
        #1;
        chk(tag, rda, model_rd(m, o, a));
        chk(tag, rdb, model_rd(m, o, b));
        @(posedge clk);
        if (w) model_wr(m, o, i, d);
    endtask

    localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                           SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011, SYS = 5'b11111;

    initial begin
        logic [4:0] modes [8];
        int seed;
        modes = '{USR, FIQ, IRQ, SVC, ABT, UND, SYS, 5'b00110};
        for (int i = 0; i < 15; i++) m_usr[i] = 0;
        for (int i = 0; i < 7; i++) m_fq[i] = 0;
        for (int k = 0; k < 4; k++) for (int j = 0; j < 2; j++) m_ex[k][j] = 0;

        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: all views read zero after reset
        for (int k = 0; k < 8; k++)
            for (int i = 0; i < 16; i += 2)
                cyc("R1", modes[k], 1'b0, 4'(i), 4'(i + 1), 1'b0, 4'd0, 32'h0);

        // R8: same-cycle read returns the old value, new value one cycle later
        cyc("R8", USR, 0, 4'd3, 4'd3, 1, 4'd3, 32'hA5A5_0003);
        chk("R8", rda, 32'h0);
        cyc("R8", USR, 0, 4'd3, 4'd4, 0, 4'd0, 32'h0);
        chk("R8", rda, 32'hA5A5_0003);
        // R2: low register visible from other modes and with override
        cyc("R2", FIQ, 0, 4'd3, 4'd3, 0, 4'd0, 32'h0);
        chk("R2", rda, 32'hA5A5_0003);
        cyc("R2", UND, 1, 4'd3, 4'd0, 0, 4'd0, 32'h0);

        // R4: fast-interrupt private 8..14
        cyc("R4", FIQ, 0, 4'd8, 4'd12, 1, 4'd8, 32'hB000_0008);
        cyc("R4", FIQ, 0, 4'd12, 4'd14, 1, 4'd14, 32'hB000_000E);
        cyc("R4", USR, 0, 4'd8, 4'd14, 0, 4'd0, 32'h0);
        chk("R4", rda, 32'h0);
        cyc("R4", IRQ, 0, 4'd14, 4'd8, 0, 4'd0, 32'h0);
        cyc("R4", FIQ, 0, 4'd8, 4'd14, 0, 4'd0, 32'h0);
        chk("R4", rdb, 32'hB000_000E);

        // R5: exception modes private 13/14, shared 8..12
        cyc("R5", IRQ, 0, 4'd13, 4'd10, 1, 4'd13, 32'hC000_000D);
        cyc("R5", SVC, 0, 4'd13, 4'd13, 1, 4'd10, 32'hD000_000A);
        cyc("R5", USR, 0, 4'd10, 4'd13, 0, 4'd0, 32'h0);
        chk("R5", rda, 32'hD000_000A);
        cyc("R5", ABT, 0, 4'd10, 4'd13, 1, 4'd14, 32'hE000_000E);
        cyc("R5", IRQ, 0, 4'd13, 4'd14, 0, 4'd0, 32'h0);
        chk("R5", rda, 32'hC000_000D);

        // R3: system shares with user, unknown code behaves as user
        cyc("R3", SYS, 0, 4'd12, 4'd13, 1, 4'd12, 32'h5555_000C);
        cyc("R3", USR, 0, 4'd12, 4'd13, 1, 4'd13, 32'h6666_000D);
        cyc("R3", 5'b00000, 0, 4'd12, 4'd13, 0, 4'd0, 32'h0);
        chk("R3", rdb, 32'h6666_000D);
        cyc("R3", 5'b10100, 0, 4'd13, 4'd14, 1, 4'd14, 32'h7777_000E);
        cyc("R3", SYS, 0, 4'd14, 4'd13, 0, 4'd0, 32'h0);
        chk("R3", rda, 32'h7777_000E);

        // R6: override sends a fast-interrupt write to the user copy
        cyc("R6", FIQ, 1, 4'd9, 4'd9, 1, 4'd9, 32'hF000_0009);
        cyc("R6", USR, 0, 4'd9, 4'd9, 0, 4'd0, 32'h0);
        chk("R6", rda, 32'hF000_0009);
        cyc("R6", FIQ, 0, 4'd9, 4'd13, 0, 4'd0, 32'h0);
        chk("R6", rda, 32'h0);
        cyc("R6", SVC, 1, 4'd13, 4'd14, 0, 4'd0, 32'h0);
        chk("R6", rda, 32'h6666_000D);

        // R7: index 15 reads zero, writes to it disturb nothing
        cyc("R7", USR, 0, 4'd15, 4'd14, 1, 4'd15, 32'hDEAD_BEEF);
        for (int i = 0; i < 16; i += 2)
            cyc("R7", USR, 0, 4'(i), 4'(i + 1), 0, 4'd0, 32'h0);
        chk("R7", rdb, 32'h0);

        // R9: random traffic, two independent read ports
        seed = $urandom(32'h1234_5678);
        for (int n = 0; n < 4000; n++) begin
            cyc("R9", modes[$urandom_range(7, 0)], ($urandom_range(7, 0) == 0),
                4'($urandom_range(15, 0)), 4'($urandom_range(15, 0)),
                ($urandom_range(1, 0) == 1), 4'($urandom_range(15, 0)), $urandom());
        end

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule